// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Generator

This block converts a signed angle in degrees into a cosine/sine pair. The angle has 16 fractional bits. The block rotates a preset start vector through a fixed sequence of shift-and-add micro-rotations. The angle is first brought into the range -180..+180 degrees by repeated whole-turn corrections, one per clock. It is then folded into -90..+90 degrees, and the fold is remembered so that the result can be negated at the end. The rotation loop runs one micro-rotation per clock against a built-in arctangent table.

A pulse on the start input launches a conversion while the block is idle. The busy output stays high until the result is ready. A one-cycle done pulse then marks the moment the I (cosine) and Q (sine) outputs take their new values. The outputs hold those values until the next conversion completes. The scale of the results comes entirely from the preset start amplitude. No further gain correction is applied.

Top module: `cordic_sincos`

## Requirements
- R1: Angles use 16 fractional bits. While the working angle is above +180·2^16, 360·2^16 is subtracted from it. While it is below -180·2^16, 360·2^16 is added to it. One correction is made per clock cycle.
- R2: Once the angle lies inside the wrap range, an angle above +90·2^16 loses 180·2^16 and an angle below -90·2^16 gains 180·2^16. Either case sets a negate flag. The values ±90·2^16 and ±180·2^16 themselves are not corrected by the wrap step.
- R3: Rotation starts with I=39797, Q=0 and an accumulated angle of 0, and runs exactly 18 steps k=0..17. The table value for step k is, in order from k=0: 2949120, 1740967, 919879, 466945, 234379, 117304, 58666, 29335, 14668, 7334, 3667, 1833, 917, 458, 229, 115, 57, 29.
- R4: In each step, the block compares the target angle with the accumulated angle as signed values. If the target is strictly greater, the step computes I-(Q>>>k) and Q+(I>>>k) and adds the table value. Otherwise it computes I+(Q>>>k) and Q-(I>>>k) and subtracts the table value. Both updates use the values held before the step, and the shifts are arithmetic on signed 32-bit values.
- R5: When the negate flag is set, both I and Q are negated before they reach the outputs.
- R6: done_o goes high for exactly one cycle, nwrap+19 rising edges after the edge that accepts start, where nwrap is the number of R1 corrections.
- R7: i_o and q_o change only on the cycle done_o rises, and otherwise hold their values.
- R8: A start while busy_o is high is ignored. The running conversion completes with its original angle and timing.
- R9: busy_o is high from the edge that accepts start until done_o rises, and low at the same time as done_o.
- R10: While rst_ni is low, busy_o, done_o, i_o and q_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a conversion when idle |
| angle_i | input | 32 | Signed angle, degrees with 16 fractional bits |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| i_o | output | 32 | Signed in-phase (cosine) result |
| q_o | output | 32 | Signed quadrature (sine) result |

## Verification
The assertions check the handshake on every cycle. They cover that done is a single-cycle pulse, that it never overlaps busy, and that the outputs hold between completions. They also check that an accepted start raises busy, and that a start mid-run cannot abort or restart the rotation counter, which must advance by one per step. Only the bench scenarios can show the numeric results and the exact latency. The bench compares each result with an arithmetic model over a wide sweep of angles. That sweep includes inputs needing many wrap steps, the exact ±90 and ±180 boundaries, and the extreme 32-bit values.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  localparam int unsigned ATAN_LEN = 18;

  typedef enum logic [1:0] {ST_IDLE, ST_WRAP, ST_ROT} cordic_state_e;

  // arctangent of 2^-k in degrees, 16 fractional bits
  function automatic logic signed [31:0] atan_deg(input int k);
    case (k)
      0:  atan_deg = 32'sd2949120;
      1:  atan_deg = 32'sd1740967;
      2:  atan_deg = 32'sd919879;
      3:  atan_deg = 32'sd466945;
      4:  atan_deg = 32'sd234379;
      5:  atan_deg = 32'sd117304;
      6:  atan_deg = 32'sd58666;
      7:  atan_deg = 32'sd29335;
      8:  atan_deg = 32'sd14668;
      9:  atan_deg = 32'sd7334;
      10: atan_deg = 32'sd3667;
      11: atan_deg = 32'sd1833;
      12: atan_deg = 32'sd917;
      13: atan_deg = 32'sd458;
      14: atan_deg = 32'sd229;
      15: atan_deg = 32'sd115;
      16: atan_deg = 32'sd57;
      17: atan_deg = 32'sd29;
      default: atan_deg = 32'sd0;
    endcase
  endfunction
endpackage

// File: rtl/cordic_range_step.sv
module cordic_range_step #(
  parameter int DW   = 32,
  parameter int FRAC = 16
) (
  input  logic signed [DW-1:0] theta_i,
  output logic signed [DW-1:0] theta_o,
  output logic                 settled_o,
  output logic                 flip_o
);
  localparam logic signed [DW-1:0] LIM90  = DW'(90 * (2 ** FRAC));
  localparam logic signed [DW-1:0] LIM180 = DW'(180 * (2 ** FRAC));
  localparam logic signed [DW-1:0] TURN   = DW'(360 * (2 ** FRAC));

  always_comb begin
    settled_o = 1'b0;
    flip_o    = 1'b0;
    if (theta_i > LIM180) begin
      theta_o = theta_i - TURN;
    end else if (theta_i < -LIM180) begin
      theta_o = theta_i + TURN;
    end else begin
      settled_o = 1'b1;
      if (theta_i > LIM90) begin
        theta_o = theta_i - LIM180;
        flip_o  = 1'b1;
      end else if (theta_i < -LIM90) begin
        theta_o = theta_i + LIM180;
        flip_o  = 1'b1;
      end else begin
        theta_o = theta_i;
      end
    end
  end
endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot #(
  parameter int DW = 32,
  parameter int SW = 5
) (
  input  logic signed [DW-1:0] i_i,
  input  logic signed [DW-1:0] q_i,
  input  logic signed [DW-1:0] acc_i,
  input  logic signed [DW-1:0] target_i,
  input  logic signed [DW-1:0] atan_i,
  input  logic        [SW-1:0] sh_i,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o,
  output logic signed [DW-1:0] acc_o
);
  logic signed [DW-1:0] i_sh, q_sh;

  assign i_sh = i_i >>> sh_i;
  assign q_sh = q_i >>> sh_i;

  always_comb begin
    if (target_i > acc_i) begin
      i_o   = i_i - q_sh;
      q_o   = q_i + i_sh;
      acc_o = acc_i + atan_i;
    end else begin
      i_o   = i_i + q_sh;
      q_o   = q_i - i_sh;
      acc_o = acc_i - atan_i;
    end
  end
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int DW        = 32,
  parameter int FRAC      = 16,
  parameter int N_ITER    = 18,
  parameter int START_AMP = 39797
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [DW-1:0] angle_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o
);
  import cordic_pkg::*;

  localparam int IW = (N_ITER > 1) ? $clog2(N_ITER) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_ITER - 1);

  cordic_state_e        state_q;
  logic signed [DW-1:0] theta_q, i_q, q_q, acc_q;
  logic                 flip_q, done_q;
  logic [IW-1:0]        idx_q;

  logic signed [DW-1:0] theta_n, i_n, q_n, acc_n, atan_cur;
  logic                 settled, flip_n, in_rot;

  assign atan_cur = DW'(atan_deg(int'(idx_q)));
  assign in_rot   = (state_q == ST_ROT);

  cordic_range_step #(.DW(DW), .FRAC(FRAC)) u_range (
    .theta_i  (theta_q),
    .theta_o  (theta_n),
    .settled_o(settled),
    .flip_o   (flip_n)
  );

  cordic_microrot #(.DW(DW), .SW(IW)) u_rot (
    .i_i     (i_q),
    .q_i     (q_q),
    .acc_i   (acc_q),
    .target_i(theta_q),
    .atan_i  (atan_cur),
    .sh_i    (idx_q),
    .i_o     (i_n),
    .q_o     (q_n),
    .acc_o   (acc_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      theta_q <= '0;
      i_q     <= '0;
      q_q     <= '0;
      acc_q   <= '0;
      flip_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            theta_q <= angle_i;
            state_q <= ST_WRAP;
          end
        end
        ST_WRAP: begin
          theta_q <= theta_n;
          if (settled) begin
            flip_q  <= flip_n;
            i_q     <= DW'(START_AMP);
            q_q     <= '0;
            acc_q   <= '0;
            idx_q   <= '0;
            state_q <= ST_ROT;
          end
        end
        ST_ROT: begin
          i_q   <= i_n;
          q_q   <= q_n;
          acc_q <= acc_n;
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) begin
            i_o     <= flip_q ? -i_n : i_n;
            q_o     <= flip_q ? -q_n : q_n;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int DW     = 32,
  parameter int N_ITER = 18,
  parameter int IW     = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic signed [DW-1:0] i_o,
  input logic signed [DW-1:0] q_o,
  input logic                 in_rot,
  input logic [IW-1:0]        rot_idx
);
  localparam logic [IW-1:0] LAST = IW'(N_ITER - 1);

  p_start_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_hold_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(i_o) && $stable(q_o)));

  p_step_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rot && rot_idx != LAST) |=> (in_rot && rot_idx == $past(rot_idx) + 1'b1));

  p_no_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(in_rot && rot_idx == LAST)) |=> busy_o);
endmodule

bind cordic_sincos cordic_sincos_chk #(.DW(DW), .N_ITER(N_ITER), .IW(IW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .i_o    (i_o),
  .q_o    (q_o),
  .in_rot (in_rot),
  .rot_idx(idx_q)
);

// File: tb/sim_cordic_sincos.sv
`timescale 1ns/1ps
module sim_cordic_sincos;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [31:0] angle = '0;
  logic busy, done;
  logic signed [31:0] iv, qv;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cordic_sincos u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .angle_i(angle),
    .busy_o(busy), .done_o(done), .i_o(iv), .q_o(qv)
  );

  localparam int LIM90  = 90 * 65536;
  localparam int LIM180 = 180 * 65536;
  localparam int TURN   = 360 * 65536;
  int atan_tab [18] = '{2949120, 1740967, 919879, 466945, 234379, 117304,
                        58666, 29335, 14668, 7334, 3667, 1833,
                        917, 458, 229, 115, 57, 29};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int a, output int ei, output int eq,
                                output int nw, output bit fl);
    int t = a;
    int x = 39797;
    int y = 0;
    int z = 0;
    nw = 0;
    fl = 1'b0;
    while (t > LIM180) begin t = t - TURN; nw++; end
    while (t < -LIM180) begin t = t + TURN; nw++; end
    if (t > LIM90) begin t = t - LIM180; fl = 1'b1; end
    else if (t < -LIM90) begin t = t + LIM180; fl = 1'b1; end
    for (int k = 0; k < 18; k++) begin
      int xn;
      if (t > z) begin
        xn = x - (y >>> k); y = y + (x >>> k); z = z + atan_tab[k];
      end else begin
        xn = x + (y >>> k); y = y - (x >>> k); z = z - atan_tab[k];
      end
      x = xn;
    end
    ei = fl ? -x : x;
    eq = fl ? -y : y;
  endfunction

  // inject: a second start with a different angle mid-run
  task automatic run(input int a, input bit inject);
    int ei, eq, nw, cnt;
    bit fl;
    model(a, ei, eq, nw, fl);
    @(negedge clk);
    start = 1'b1;
    angle = a;
    cnt = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      angle = ~a;
      cnt++;
      if (cnt == 1) chk("R9 busy after start", busy, 1);
      if (inject && cnt == 4) begin start = 1'b1; angle = a + 32'sd5000000; end
    end while (!done && cnt < 400);
    chk(inject ? "R8 latency with ignored start" : "R1 R6 latency", cnt, nw + 20);
    chk("R9 busy low with done", busy, 0);
    chk(fl ? "R2 R5 I result" : "R3 R4 I result", iv, ei);
    chk(fl ? "R2 R5 Q result" : "R3 R4 Q result", qv, eq);
    @(negedge clk);
    chk("R6 done single cycle", done, 0);
    repeat (2) @(negedge clk);
    chk("R7 I held", iv, ei);
    chk("R7 Q held", qv, eq);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", busy, 0);
    chk("R10 done in reset", done, 0);
    chk("R10 I in reset", iv, 0);
    chk("R10 Q in reset", qv, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // boundaries
    run(0, 1'b0);
    run(LIM90, 1'b0);
    run(-LIM90, 1'b0);
    run(LIM90 + 1, 1'b0);
    run(-LIM90 - 1, 1'b0);
    run(LIM180, 1'b0);
    run(-LIM180, 1'b0);
    run(LIM180 + 1, 1'b0);
    run(-LIM180 - 1, 1'b0);
    run(32'sh7fffffff, 1'b0);
    run(32'sh80000000, 1'b0);
    // ignored start during a run
    run(30 * 65536, 1'b1);
    run(-2000 * 65536, 1'b1);
    // wide sweep
    for (int k = -300; k <= 300; k++) run(k * 7000003, 1'b0);
    // fine sweep over one turn
    for (int d = -190; d <= 190; d += 5) run(d * 65536 + 12345, 1'b0);

    // start held while idle after done is accepted normally
    run(45 * 65536, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule